// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Watermarks

This block is a first-in first-out buffer of 64 words of 18 bits that sits between two clock domains. Words enter on a rising edge of the load clock while the load request is high and leave on a rising edge of the unload clock while the unload request is high. The two clocks may be unrelated or the same net. The requests qualify each clock edge, so the clocks can run freely and the pointer synchronizers keep moving.

Status comes out as active-low full and empty flags, a half-full flag and one combined watermark flag. The watermark flag is high when the buffer is nearly empty or nearly full. After reset, the two watermark offsets can be loaded through the data input on the first one or two qualified load edges while the program input is held low. Those edges store no word. An output enable gates the read data.

Top module: `dual_clk_wm_fifo`

## Requirements
- R1: Words are unloaded in the order they were loaded, all 18 bits intact. A qualified unload edge presents the oldest word on `rd_data`, where it stays until the next accepted unload.
- R2: `full_n` goes low on the load edge that brings occupancy to 64. A load request while `full_n` is low leaves the stored words and their order unchanged.
- R3: An unload request while `empty_n` is low changes neither `rd_data` nor the stored contents.
- R4: `empty_n` is low after reset. It goes high a few unload cycles after a word is loaded, and goes low on the unload edge that removes the last word.
- R5: `half_full` is high when occupancy is 32 or more and low when it is 31 or fewer.
- R6: While `prog_n` is low, the first qualified load edge after reset takes the low offset X from `ld_in[5:0]` and the second takes the high offset Y from `ld_in[5:0]`. Neither edge stores a word. A qualified load with `prog_n` high closes the programming window.
- R7: `almost` is high when occupancy is at most X or at least 64 − Y, and low when it lies from X+1 through 63 − Y.
- R8: If the programming window closes after a single programming edge, Y takes the value of X.
- R9: Without programming, X and Y are both 8.
- R10: While `out_en` is low, `rd_data` is all zeros and `rd_valid` is low. Raising `out_en` shows the held word again.
- R11: An asynchronous low on `rst_n` empties the buffer at once: `empty_n` low, `full_n` high, `half_full` low, `almost` high. Offsets return to 8 and programming is re-armed.
- R12: Each domain's Gray pointer changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_clk | input | 1 | Load clock |
| wr_req | input | 1 | Qualifies a load-clock edge as a load or programming edge |
| prog_n | input | 1 | Offset programming enable, active low |
| ld_in | input | 18 | Data word or offset value |
| unld_clk | input | 1 | Unload clock |
| rd_req | input | 1 | Qualifies an unload-clock edge as an unload |
| out_en | input | 1 | Output enable for the read data |
| rd_data | output | 18 | Last unloaded word, zero when disabled |
| rd_valid | output | 1 | High while the read data is driven |
| full_n | output | 1 | Low when 64 words are held |
| empty_n | output | 1 | Low when no word is held |
| half_full | output | 1 | High at 32 or more words |
| almost | output | 1 | Combined almost-empty / almost-full flag |

## Verification
The assertions assume the requests change away from their clock edges and that `rst_n` is held low across at least one edge of each clock. They also assume the bench only looks at load-domain flags once the read pointer has crossed over. The bench drives every request on a falling edge. After any unload it waits several cycles of both clocks before it samples `half_full`, `almost` or `empty_n`. Flag thresholds are probed only during fill phases, where the read pointer is still and the occupancy seen by the load domain is exact.

// File: rtl/fifo_wm_pkg.sv
package fifo_wm_pkg;

    // Phase of the offset programming window in the load domain
    typedef enum logic [1:0] {
        PH_LOW_OFS  = 2'd0,
        PH_HIGH_OFS = 2'd1,
        PH_RUN      = 2'd2
    } prog_phase_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b = g;
        for (int s = 1; s < 32; s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_wm_sync2.sv
module fifo_wm_sync2 #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/fifo_wm_store.sv
module fifo_wm_store #(
    parameter int W  = 18,
    parameter int AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fifo_wm_load_side.sv
module fifo_wm_load_side
    import fifo_wm_pkg::*;
#(
    parameter int AW      = 6,
    parameter int DEF_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic          prog_n,
    input  logic [AW-1:0] ofs_in,
    input  logic [AW:0]   rgray_sync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          half,
    output logic          almost
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
    localparam logic [AW-1:0] DEF_P   = AW'(DEF_OFS);

    typedef struct packed {
        logic [PW-1:0] wbin;
        logic [PW-1:0] wgray;
        prog_phase_e   phase;
        logic [AW-1:0] ofs_lo;
        logic [AW-1:0] ofs_hi;
        logic          full;
        logic          half;
        logic          almost;
    } ld_st_t;

    ld_st_t        st_d, st_q;
    logic          prog_edge;
    logic [PW-1:0] rbin_sync;
    logic [PW-1:0] occ;

    always_comb begin
        st_d      = st_q;
        we        = 1'b0;
        prog_edge = wr_req && !prog_n && (st_q.phase != PH_RUN);

        if (wr_req) begin
            if (prog_edge) begin
                if (st_q.phase == PH_LOW_OFS) begin
                    st_d.ofs_lo = ofs_in;
                    st_d.ofs_hi = ofs_in;
                    st_d.phase  = PH_HIGH_OFS;
                end else begin
                    st_d.ofs_hi = ofs_in;
                    st_d.phase  = PH_RUN;
                end
            end else begin
                st_d.phase = PH_RUN;
                if (!st_q.full) begin
                    we        = 1'b1;
                    st_d.wbin = st_q.wbin + 1'b1;
                end
            end
        end

        st_d.wgray  = PW'(bin_to_gray(32'(st_d.wbin)));
        rbin_sync   = PW'(gray_to_bin(32'(rgray_sync)));
        occ         = st_d.wbin - rbin_sync;
        st_d.full   = (occ == DEPTH_P);
        st_d.half   = (occ >= HALF_P);
        st_d.almost = (occ <= {1'b0, st_d.ofs_lo}) ||
                      (occ >= (DEPTH_P - {1'b0, st_d.ofs_hi}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wbin   <= '0;
            st_q.wgray  <= '0;
            st_q.phase  <= PH_LOW_OFS;
            st_q.ofs_lo <= DEF_P;
            st_q.ofs_hi <= DEF_P;
            st_q.full   <= 1'b0;
            st_q.half   <= 1'b0;
            st_q.almost <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr  = st_q.wbin[AW-1:0];
    assign wbin   = st_q.wbin;
    assign wgray  = st_q.wgray;
    assign full   = st_q.full;
    assign half   = st_q.half;
    assign almost = st_q.almost;
endmodule

// File: rtl/fifo_wm_unload_side.sv
module fifo_wm_unload_side
    import fifo_wm_pkg::*;
#(
    parameter int W  = 18,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW:0]   wgray_sync,
    input  logic [W-1:0]  mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic [W-1:0]  dout
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] rbin;
        logic [PW-1:0] rgray;
        logic          empty;
        logic [W-1:0]  dout;
    } ul_st_t;

    ul_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_req && !st_q.empty) begin
            st_d.dout = mem_rdata;
            st_d.rbin = st_q.rbin + 1'b1;
        end
        st_d.rgray = PW'(bin_to_gray(32'(st_d.rbin)));
        st_d.empty = (st_d.rgray == wgray_sync);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rbin  <= '0;
            st_q.rgray <= '0;
            st_q.empty <= 1'b1;
            st_q.dout  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr = st_q.rbin[AW-1:0];
    assign rbin  = st_q.rbin;
    assign rgray = st_q.rgray;
    assign empty = st_q.empty;
    assign dout  = st_q.dout;
endmodule

// File: rtl/dual_clk_wm_fifo.sv
module dual_clk_wm_fifo #(
    parameter int DATA_W  = 18,
    parameter int ADDR_W  = 6,
    parameter int DEF_OFS = 8
) (
    input  logic              rst_n,
    input  logic              ld_clk,
    input  logic              wr_req,
    input  logic              prog_n,
    input  logic [DATA_W-1:0] ld_in,
    input  logic              unld_clk,
    input  logic              rd_req,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              full_n,
    output logic              empty_n,
    output logic              half_full,
    output logic              almost
);
    localparam int PW = ADDR_W + 1;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PW-1:0]     w_bin, w_gray, r_bin, r_gray;
    logic [PW-1:0]     rgray_in_ld, wgray_in_ul;
    logic              full_flag, empty_flag, half_flag, almost_flag;
    logic [DATA_W-1:0] dout;

    fifo_wm_store #(.W(DATA_W), .AW(ADDR_W)) i_store (
        .wclk (ld_clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(ld_in),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    fifo_wm_sync2 #(.W(PW)) i_sync_r2l (
        .clk    (ld_clk),
        .rst_n  (rst_n),
        .async_i(r_gray),
        .sync_o (rgray_in_ld)
    );

    fifo_wm_sync2 #(.W(PW)) i_sync_w2u (
        .clk    (unld_clk),
        .rst_n  (rst_n),
        .async_i(w_gray),
        .sync_o (wgray_in_ul)
    );

    fifo_wm_load_side #(.AW(ADDR_W), .DEF_OFS(DEF_OFS)) i_load (
        .clk       (ld_clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .prog_n    (prog_n),
        .ofs_in    (ld_in[ADDR_W-1:0]),
        .rgray_sync(rgray_in_ld),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wbin      (w_bin),
        .wgray     (w_gray),
        .full      (full_flag),
        .half      (half_flag),
        .almost    (almost_flag)
    );

    fifo_wm_unload_side #(.W(DATA_W), .AW(ADDR_W)) i_unload (
        .clk       (unld_clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wgray_sync(wgray_in_ul),
        .mem_rdata (mem_rdata),
        .raddr     (mem_raddr),
        .rbin      (r_bin),
        .rgray     (r_gray),
        .empty     (empty_flag),
        .dout      (dout)
    );

    assign full_n    = ~full_flag;
    assign empty_n   = ~empty_flag;
    assign half_full = half_flag;
    assign almost    = almost_flag;
    assign rd_valid  = out_en;
    assign rd_data   = out_en ? dout : '0;
endmodule

// File: rtl/fifo_wm_checker.sv
module fifo_wm_checker #(
    parameter int PW = 7
) (
    input logic          rst_n,
    input logic          ld_clk,
    input logic          unld_clk,
    input logic          wr_req,
    input logic          rd_req,
    input logic          full_n,
    input logic          empty_n,
    input logic          half_full,
    input logic          almost,
    input logic [PW-1:0] w_bin,
    input logic [PW-1:0] r_bin,
    input logic [PW-1:0] w_gray,
    input logic [PW-1:0] r_gray
);
    assert_full_blocks_load_R2: assert property (@(posedge ld_clk) disable iff (!rst_n)
        (!full_n && wr_req) |=> $stable(w_bin));

    assert_empty_blocks_unload_R3: assert property (@(posedge unld_clk) disable iff (!rst_n)
        (!empty_n && rd_req) |=> $stable(r_bin));

    assert_full_implies_half_R5: assert property (@(posedge ld_clk) disable iff (!rst_n)
        !full_n |-> half_full);

    assert_full_implies_almost_R7: assert property (@(posedge ld_clk) disable iff (!rst_n)
        !full_n |-> almost);

    assert_wgray_single_step_R12: assert property (@(posedge ld_clk) disable iff (!rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    assert_rgray_single_step_R12: assert property (@(posedge unld_clk) disable iff (!rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);
endmodule

bind dual_clk_wm_fifo fifo_wm_checker #(.PW(PW)) i_checker (
    .rst_n    (rst_n),
    .ld_clk   (ld_clk),
    .unld_clk (unld_clk),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .half_full(half_full),
    .almost   (almost),
    .w_bin    (w_bin),
    .r_bin    (r_bin),
    .w_gray   (w_gray),
    .r_gray   (r_gray)
);

// File: tb/test_dual_clk_wm_fifo.sv
module test_dual_clk_wm_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int UNLD_PERIOD = CLK_PERIOD + 4;

    logic        rst_n = 1'b1;
    logic        ld_clk = 1'b0;
    logic        unld_clk = 1'b0;
    logic        wr_req = 1'b0;
    logic        prog_n = 1'b1;
    logic [17:0] ld_in = '0;
    logic        rd_req = 1'b0;
    logic        out_en = 1'b1;
    logic [17:0] rd_data;
    logic        rd_valid, full_n, empty_n, half_full, almost;

    int          n_checks = 0;
    int          n_fails = 0;
    logic [17:0] exp_q[$];
    logic [17:0] mon_exp;
    string       mon_tag = "R1";
    event        word_out;

    always #(CLK_PERIOD / 2) ld_clk = ~ld_clk;
    always #(UNLD_PERIOD / 2) unld_clk = ~unld_clk;

    dual_clk_wm_fifo i_dual_clk_wm_fifo (
        .rst_n(rst_n), .ld_clk(ld_clk), .wr_req(wr_req), .prog_n(prog_n),
        .ld_in(ld_in), .unld_clk(unld_clk), .rd_req(rd_req), .out_en(out_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .full_n(full_n),
        .empty_n(empty_n), .half_full(half_full), .almost(almost)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one qualified load edge; stored words go to the scoreboard
    task automatic load_word(input logic [17:0] d, input bit store);
        @(negedge ld_clk);
        ld_in  = d;
        wr_req = 1'b1;
        @(negedge ld_clk);
        wr_req = 1'b0;
        if (store) exp_q.push_back(d);
    endtask

    task automatic unload_raw();
        @(negedge unld_clk);
        rd_req = 1'b1;
        @(negedge unld_clk);
        rd_req = 1'b0;
    endtask

    task automatic unload_word(input string tag);
        mon_tag = tag;
        unload_raw();
        -> word_out;
        #1;
    endtask

    task automatic settle();
        repeat (4) @(negedge unld_clk);
        repeat (4) @(negedge ld_clk);
    endtask

    task automatic do_reset();
        @(negedge ld_clk);
        rst_n = 1'b0;
        repeat (2) @(negedge unld_clk);
        @(negedge ld_clk);
        rst_n = 1'b1;
        exp_q.delete();
    endtask

    // Monitor: compare each unloaded word with the scoreboard head
    always @(word_out) begin
        if (exp_q.size() == 0) begin
            check({mon_tag, " scoreboard empty"}, 32'(rd_data), 32'hFFFFFFFF);
        end else begin
            mon_exp = exp_q.pop_front();
            check(mon_tag, 32'(rd_data), 32'(mon_exp));
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [17:0] held;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge unld_clk);
        @(negedge ld_clk);
        rst_n = 1'b1;

        // R11 / R4: reset state
        check("R4 reset empty_n", 32'(empty_n), 0);
        check("R11 reset full_n", 32'(full_n), 1);
        check("R11 reset half_full", 32'(half_full), 0);
        check("R11 reset almost", 32'(almost), 1);

        // R9 defaults, R5 half threshold, R2 full
        for (int n = 1; n <= 64; n++) begin
            load_word(18'h2A000 + 18'(n), 1'b1);
            if (n == 8)  check("R9 almost at 8", 32'(almost), 1);
            if (n == 9)  check("R9 almost at 9", 32'(almost), 0);
            if (n == 31) check("R5 half at 31", 32'(half_full), 0);
            if (n == 32) check("R5 half at 32", 32'(half_full), 1);
            if (n == 55) check("R9 almost at 55", 32'(almost), 0);
            if (n == 56) check("R9 almost at 56", 32'(almost), 1);
            if (n == 63) check("R2 full_n at 63", 32'(full_n), 1);
        end
        check("R2 full_n at 64", 32'(full_n), 0);
        check("R4 empty_n after loads", 32'(empty_n), 1);
        load_word(18'h3FFFF, 1'b0);
        load_word(18'h15555, 1'b0);
        check("R2 full_n held", 32'(full_n), 0);
        for (int n = 0; n < 64; n++) unload_word("R1 R2 order");
        check("R4 empty_n after last", 32'(empty_n), 0);
        settle();
        check("R2 full_n after drain", 32'(full_n), 1);
        check("R5 half after drain", 32'(half_full), 0);

        // R3: unload while empty
        held = rd_data;
        unload_raw();
        check("R3 rd_data unchanged", 32'(rd_data), 32'(held));
        check("R3 empty_n stays low", 32'(empty_n), 0);
        load_word(18'h01234, 1'b1);
        settle();
        unload_word("R3 next word");

        // R10: output enable gating
        load_word(18'h2BEEF, 1'b0);
        settle();
        out_en = 1'b0;
        unload_raw();
        #1;
        check("R10 data gated", 32'(rd_data), 0);
        check("R10 valid low", 32'(rd_valid), 0);
        out_en = 1'b1;
        #1;
        check("R10 data shown", 32'(rd_data), 32'h2BEEF);
        check("R10 valid high", 32'(rd_valid), 1);

        // R11: asynchronous reset mid-cycle
        for (int n = 0; n < 40; n++) load_word(18'h10000 + 18'(n), 1'b0);
        @(negedge ld_clk);
        #2 rst_n = 1'b0;
        #1;
        check("R11 async empty_n", 32'(empty_n), 0);
        check("R11 async full_n", 32'(full_n), 1);
        check("R11 async half", 32'(half_full), 0);
        check("R11 async almost", 32'(almost), 1);
        repeat (2) @(negedge unld_clk);
        @(negedge ld_clk);
        rst_n = 1'b1;
        exp_q.delete();

        // R6 / R7: program X=3, Y=5 with junk upper bits
        prog_n = 1'b0;
        load_word(18'h3FFC3, 1'b0);
        load_word(18'h2AA45, 1'b0);
        prog_n = 1'b1;
        check("R6 program edges store nothing", 32'(empty_n), 0);
        for (int n = 1; n <= 59; n++) begin
            load_word(18'h30000 + 18'(n), 1'b1);
            if (n == 3)  check("R7 almost at X", 32'(almost), 1);
            if (n == 4)  check("R7 almost at X+1", 32'(almost), 0);
            if (n == 58) check("R7 almost at 63-Y", 32'(almost), 0);
            if (n == 59) check("R7 almost at 64-Y", 32'(almost), 1);
        end
        settle();
        for (int n = 0; n < 59; n++) unload_word("R6 first word after programming");
        settle();
        check("R7 almost after drain", 32'(almost), 1);

        // R8: one programming edge, Y follows X=10
        do_reset();
        prog_n = 1'b0;
        load_word(18'h0000A, 1'b0);
        prog_n = 1'b1;
        for (int n = 1; n <= 54; n++) begin
            load_word(18'h0C000 + 18'(n), 1'b1);
            if (n == 10) check("R8 almost at 10", 32'(almost), 1);
            if (n == 11) check("R8 almost at 11", 32'(almost), 0);
            if (n == 53) check("R8 almost at 53", 32'(almost), 0);
            if (n == 54) check("R8 almost at 54", 32'(almost), 1);
        end
        settle();
        for (int n = 0; n < 54; n++) unload_word("R8 R1 order");
        check("R4 empty at end", 32'(empty_n), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule